// File: doc/BRIEF.md
# SPI Master with On-Demand FIFO Feed

This block is a serial peripheral interface master that fetches each transmit word from an external FIFO only when it needs it. It raises a request and takes the word in the cycle the FIFO answers with valid data. Each word is shifted out on MOSI, most significant bit first, while the word the slave returns on MISO is captured. Each completed received word appears with a one-cycle valid pulse. A burst keeps one slave select asserted for as many words as the FIFO supplies. The burst closes when the FIFO reports that it is empty.

Software-side logic sets clock polarity, clock phase, a divide code for the serial clock and the index of the target slave through a single-cycle configuration write. The master refuses a forbidden configuration with a sticky error flag and will not start while that flag is set. A FIFO that gives neither data nor an empty indication within a bounded number of cycles also ends the burst, with a separate error flag. Word length, the number of slave-select lines and the FIFO wait limit are compile-time parameters.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, sclk is 0, every ss_n line is 1, mosi is 0, and fifo_req, rx_valid, busy, cfg_err and fifo_err are all 0. The reset configuration is polarity 0, phase 0, divide code 0 and slave 0.
- R2: While idle, sclk rests at the polarity of the last accepted configuration.
- R3: Data moves most significant bit first. With phase 0, the first bit is on mosi before the first SCLK edge, the master samples on leading edges and changes mosi on trailing edges. With phase 1, mosi changes on leading edges and the master samples on trailing edges. A slave that follows the same rule receives every FIFO word unchanged.
- R4: Divide code 0 makes SCLK system clock / 2, so each SCLK level lasts 1 clock. Divide code 1 makes SCLK system clock / 4, so each level lasts 2 clocks.
- R5: fifo_req is high in every cycle in which the master waits for a word. A word is taken in a cycle where fifo_req and fifo_valid are both high. Each taken word is sent exactly once, in FIFO order.
- R6: One ss_n line stays low for the whole burst. It rises exactly H+1 clocks after the final SCLK edge when fifo_empty answers the first request after that edge, where H is the SCLK half period in clocks. Outside a burst every ss_n line is 1.
- R7: If neither fifo_valid nor fifo_empty arrives, fifo_req stays high for exactly FIFO_WAIT cycles (16 by default). Then fifo_req drops, fifo_err is set and the burst ends. fifo_err clears at the next accepted start.
- R8: A configuration write with divide code 2 or 3, or with a slave index of NUM_SS or more, sets cfg_err and leaves the previous configuration in force. A later legal write clears cfg_err. A start pulse has no effect while cfg_err is 1.
- R9: Configuration writes made while busy is 1 change neither the configuration nor cfg_err.
- R10: Bit k of ss_n is the select for slave index k, active low, and at most one line is low at any time.
- R11: rx_valid is a single-cycle pulse for each completed word, and rx_data holds the word received from the slave during that word.
- R12: A start while the FIFO reports empty on the first request ends with no slave selected and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cpol | input | 1 | Clock polarity (SCLK idle level) |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge) |
| cfg_div | input | 2 | Divide code: 0 = /2, 1 = /4, 2 and 3 are illegal |
| cfg_slave | input | SS_W | Target slave index |
| start | input | 1 | Begin a burst |
| busy | output | 1 | Burst in progress |
| cfg_err | output | 1 | Last configuration write was refused |
| fifo_err | output | 1 | FIFO failed to answer in time |
| fifo_req | output | 1 | Request for the next transmit word |
| fifo_valid | input | 1 | FIFO supplies a word this cycle |
| fifo_empty | input | 1 | FIFO has no word, so the burst ends |
| fifo_data | input | WORD_W | Transmit word from the FIFO |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | rx_data updated this cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | NUM_SS | Slave selects, active low |

## Verification
A corrupted edge counter or shift register shows up within one word: the slave model on the bench captures a wrong MOSI word, the word in rx_data is wrong, or the spacing between SCLK edges departs from the divide code, all before the next rx_valid pulse. A state machine stuck in the wait state shows as fifo_req held longer than the wait limit, which the bench detects within FIFO_WAIT cycles. A select or tail error changes the timing of the ss_n rise, which is checked to the exact clock at the end of each burst. An idle level or configuration register that has taken a write it should have refused shows at sclk within two cycles of returning to idle.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_XFER,
      ST_TAIL
   } sfm_state_e;

   localparam logic [1:0] DIV_BY2 = 2'd0;
   localparam logic [1:0] DIV_BY4 = 2'd1;
   localparam int MAX_HALF = 2;
   localparam int HC_W = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

   function automatic logic div_legal(input logic [1:0] code);
      return (code == DIV_BY2) || (code == DIV_BY4);
   endfunction

   function automatic logic [HC_W-1:0] half_limit(input logic [1:0] code);
      return (code == DIV_BY4) ? HC_W'(1) : HC_W'(0);
   endfunction
endpackage

// File: rtl/sfm_sclk_gen.sv
module sfm_sclk_gen
   import sfm_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            cpol,
   input  logic [HC_W-1:0] half_lim,
   output logic            sclk,
   output logic            tick,
   output logic            lead,
   output logic            last
);
   localparam int EDGES = 2 * WORD_W;
   localparam int EC_W = $clog2(EDGES);

   logic [HC_W-1:0] hcnt;
   logic [EC_W-1:0] ecnt;

   assign tick = run && (hcnt == half_lim);
   assign lead = ~ecnt[0];
   assign last = (ecnt == EC_W'(EDGES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         ecnt <= '0;
         sclk <= 1'b0;
      end else if (!run) begin
         hcnt <= '0;
         ecnt <= '0;
         sclk <= cpol;
      end else if (tick) begin
         hcnt <= '0;
         ecnt <= last ? '0 : ecnt + 1'b1;
         sclk <= ~sclk;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              cpha,
   input  logic              tick,
   input  logic              lead,
   input  logic              last,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid
);
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic [WORD_W-1:0] rx_next;
   logic              do_sample;
   logic              do_shift;

   assign do_sample = tick && (lead ^ cpha);
   assign do_shift  = tick && !(lead ^ cpha);
   assign rx_next   = {rx_sh[WORD_W-2:0], miso};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh    <= '0;
         rx_sh    <= '0;
         mosi     <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= tick && last;
         if (load) begin
            if (!cpha) begin
               mosi  <= word[WORD_W-1];
               tx_sh <= {word[WORD_W-2:0], 1'b0};
            end else begin
               tx_sh <= word;
            end
         end else if (do_shift) begin
            mosi  <= tx_sh[WORD_W-1];
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
         end
         if (do_sample) rx_sh <= rx_next;
         if (tick && last) rx_data <= do_sample ? rx_next : rx_sh;
      end
   end
endmodule

// File: rtl/sfm_ss_decode.sv
module sfm_ss_decode #(
   parameter int NUM_SS = 3,
   parameter int SS_W = 2
) (
   input  logic [SS_W-1:0]   sel,
   input  logic              active,
   output logic [NUM_SS-1:0] ss_n
);
   for (genvar g = 0; g < NUM_SS; g++) begin : g_line
      assign ss_n[g] = !(active && (sel == SS_W'(g)));
   end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import sfm_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int NUM_SS = 3,
   parameter int FIFO_WAIT = 16,
   localparam int SS_W = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [1:0]        cfg_div,
   input  logic [SS_W-1:0]   cfg_slave,
   input  logic              start,
   output logic              busy,
   output logic              cfg_err,
   output logic              fifo_err,
   output logic              fifo_req,
   input  logic              fifo_valid,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_data,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n
);
   localparam int WT_W = $clog2(FIFO_WAIT + 1);
   localparam logic [SS_W:0] SS_CNT = (SS_W+1)'(NUM_SS);

   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (FIFO_WAIT < 1) begin : g_bad_wait
      $error("FIFO_WAIT must be at least 1");
   end
   if (NUM_SS < 1) begin : g_bad_ss
      $error("NUM_SS must be at least 1");
   end

   sfm_state_e      state;
   logic            cpol_q, cpha_q;
   logic [1:0]      div_q;
   logic [SS_W-1:0] sel_q;
   logic            cfg_err_q, fifo_err_q, ss_act;
   logic [WT_W-1:0] wcnt;
   logic [HC_W-1:0] tcnt;
   logic [HC_W-1:0] half_lim;
   logic            cfg_ok, load, run, tick, lead, last;

   assign cfg_ok   = div_legal(cfg_div) && ({1'b0, cfg_slave} < SS_CNT);
   assign half_lim = half_limit(div_q);
   assign run      = (state == ST_XFER);
   assign load     = (state == ST_REQ) && fifo_valid;
   assign fifo_req = (state == ST_REQ);
   assign busy     = (state != ST_IDLE);
   assign cfg_err  = cfg_err_q;
   assign fifo_err = fifo_err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpol_q    <= 1'b0;
         cpha_q    <= 1'b0;
         div_q     <= DIV_BY2;
         sel_q     <= '0;
         cfg_err_q <= 1'b0;
      end else if (cfg_we && state == ST_IDLE) begin
         if (cfg_ok) begin
            cpol_q    <= cfg_cpol;
            cpha_q    <= cfg_cpha;
            div_q     <= cfg_div;
            sel_q     <= cfg_slave;
            cfg_err_q <= 1'b0;
         end else begin
            cfg_err_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         wcnt       <= '0;
         tcnt       <= '0;
         ss_act     <= 1'b0;
         fifo_err_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start && !cfg_err_q) begin
               state      <= ST_REQ;
               wcnt       <= '0;
               fifo_err_q <= 1'b0;
            end
            ST_REQ: begin
               tcnt <= '0;
               if (fifo_valid) begin
                  state  <= ST_XFER;
                  ss_act <= 1'b1;
                  wcnt   <= '0;
               end else if (fifo_empty) begin
                  state <= ST_TAIL;
               end else if (wcnt == WT_W'(FIFO_WAIT - 1)) begin
                  state      <= ST_TAIL;
                  fifo_err_q <= 1'b1;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            ST_XFER: if (tick && last) begin
               state <= ST_REQ;
               wcnt  <= '0;
            end
            ST_TAIL: begin
               if (tcnt == half_lim) begin
                  state  <= ST_IDLE;
                  ss_act <= 1'b0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   sfm_sclk_gen #(.WORD_W(WORD_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol_q), .half_lim(half_lim),
      .sclk(sclk), .tick(tick), .lead(lead), .last(last)
   );

   sfm_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .word(fifo_data), .cpha(cpha_q),
      .tick(tick), .lead(lead), .last(last), .miso(miso),
      .mosi(mosi), .rx_data(rx_data), .rx_valid(rx_valid)
   );

   sfm_ss_decode #(.NUM_SS(NUM_SS), .SS_W(SS_W)) u_ss (
      .sel(sel_q), .active(ss_act), .ss_n(ss_n)
   );
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
   parameter int NUM_SS = 3,
   parameter int FIFO_WAIT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_SS-1:0] ss_n,
   input logic              fifo_req,
   input logic              rx_valid,
   input logic              busy,
   input logic              cfg_err,
   input logic              fifo_err
);
   localparam int RR_W = $clog2(FIFO_WAIT + 2) + 1;
   logic [RR_W-1:0] req_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_run <= '0;
      else if (fifo_req) req_run <= (req_run == '1) ? req_run : req_run + 1'b1;
      else req_run <= '0;
   end

   assert_ss_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ss_n));

   assert_rx_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_cfgerr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !busy);

   assert_idle_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&ss_n));

   assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_req |-> (req_run < RR_W'(FIFO_WAIT)));

   assert_timeout_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_err) |-> !fifo_req);
endmodule

bind spi_fifo_master sfm_checker #(.NUM_SS(NUM_SS), .FIFO_WAIT(FIFO_WAIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .fifo_req(fifo_req), .rx_valid(rx_valid),
   .busy(busy), .cfg_err(cfg_err), .fifo_err(fifo_err)
);

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
   localparam int W = 8;
   localparam int NSS = 3;
   localparam int WAITC = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_cpol = 0, cfg_cpha = 0;
   logic [1:0] cfg_div = 0, cfg_slave = 0;
   logic start = 0;
   logic busy, cfg_err, fifo_err, fifo_req, rx_valid, sclk, mosi;
   logic fifo_valid = 0, fifo_empty = 0, miso = 0;
   logic [W-1:0] fifo_data = 0, rx_data;
   logic [NSS-1:0] ss_n;

   spi_fifo_master #(.WORD_W(W), .NUM_SS(NSS), .FIFO_WAIT(WAITC)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_div(cfg_div), .cfg_slave(cfg_slave), .start(start), .busy(busy),
      .cfg_err(cfg_err), .fifo_err(fifo_err), .fifo_req(fifo_req), .fifo_valid(fifo_valid),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .rx_data(rx_data), .rx_valid(rx_valid),
      .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   always #2 clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // bench-side configuration mirror, written by the main flow only
   logic [7:0] cur_seed = 0;
   logic cur_cpha = 0;
   int cur_h = 1, cur_sel = 0, n_words = 0;
   bit fifo_on = 1;

   function automatic logic [7:0] txw(input logic [7:0] s, input int i);
      return 8'(s + 8'(i * 59)) ^ 8'(i << 4);
   endfunction
   function automatic logic [7:0] slw(input logic [7:0] s, input int i);
      return 8'(~s) + 8'(i * 97) + 8'h11;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // FIFO model: answers every request in the same cycle it sees it
   int fed = 0;
   always @(negedge clk) begin
      fifo_valid = 0;
      fifo_empty = 0;
      if (!busy) fed = 0;
      if (fifo_req && fifo_on) begin
         if (fed < n_words) begin
            fifo_valid = 1;
            fifo_data = txw(cur_seed, fed);
            fed++;
         end else begin
            fifo_empty = 1;
         end
      end
   end

   // Slave model and port monitor
   int ncyc = 0, last_edge = 0, mon_edge = 0, widx = 0, rx_idx = 0;
   int words_done = 0, bad_mosi = 0, bad_half = 0, bad_sel = 0, rx_seen = 0, bad_rx = 0;
   int ss_falls = 0, last_tail = 0;
   logic prev_sclk = 0;
   logic [NSS-1:0] prev_ss = '1;
   logic [7:0] mon_rx = 0, mon_tx = 0;
   always @(negedge clk) begin
      ncyc++;
      if (rst_n) begin
         if (&prev_ss && !(&ss_n)) begin
            ss_falls++;
            widx = 0; mon_edge = 0; rx_idx = 0;
            if (ss_n != ~(NSS'(1) << cur_sel)) bad_sel++;
            mon_tx = slw(cur_seed, 0);
            if (!cur_cpha) begin miso = mon_tx[7]; mon_tx = mon_tx << 1; end
         end
         if (!(&ss_n) && sclk != prev_sclk) begin
            if (mon_edge > 0 && (ncyc - last_edge) != cur_h) bad_half++;
            last_edge = ncyc;
            if ((mon_edge % 2 == 0) ^ cur_cpha) mon_rx = {mon_rx[6:0], mosi};
            else begin miso = mon_tx[7]; mon_tx = mon_tx << 1; end
            mon_edge++;
            if (mon_edge == 2 * W) begin
               if (mon_rx != txw(cur_seed, widx)) bad_mosi++;
               words_done++;
               widx++;
               mon_edge = 0;
               mon_tx = slw(cur_seed, widx);
               if (!cur_cpha) begin miso = mon_tx[7]; mon_tx = mon_tx << 1; end
            end
         end
         if (!(&prev_ss) && (&ss_n)) last_tail = ncyc - last_edge;
         if (rx_valid) begin
            rx_seen++;
            if (rx_data != slw(cur_seed, rx_idx)) bad_rx++;
            rx_idx++;
         end
      end
      prev_sclk = sclk;
      prev_ss = ss_n;
   end

   task automatic cfg_write(input logic p, input logic ph, input logic [1:0] d, input logic [1:0] s);
      @(negedge clk);
      cfg_cpol = p; cfg_cpha = ph; cfg_div = d; cfg_slave = s; cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 4000 && busy; k++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // {cpol, cpha, div[1:0], slave[1:0], words[2:0], seed[7:0]}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 1'b0, 2'd0, 2'd0, 3'd1, 8'hA5},
      {1'b0, 1'b1, 2'd0, 2'd1, 3'd2, 8'h3C},
      {1'b1, 1'b0, 2'd1, 2'd2, 3'd3, 8'hF0},
      {1'b1, 1'b1, 2'd1, 2'd0, 3'd2, 8'h5A},
      {1'b1, 1'b1, 2'd0, 2'd2, 3'd4, 8'h81},
      {1'b0, 1'b0, 2'd1, 2'd1, 3'd3, 8'h17}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sclk == 0 && mosi == 0, "R1 sclk/mosi", {sclk, mosi}, 0);
      chk(ss_n == '1, "R1 ss_n", ss_n, 7);
      chk({fifo_req, rx_valid, busy, cfg_err, fifo_err} == 0, "R1 flags",
          {fifo_req, rx_valid, busy, cfg_err, fifo_err}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 6; v++) begin
         logic [16:0] e;
         int w0, bm0, bh0, bs0, rs0, br0;
         e = VEC[v];
         cfg_write(e[16], e[15], e[14:13], e[12:11]);
         cur_cpha = e[15]; cur_h = (e[14:13] == 2'd1) ? 2 : 1; cur_sel = int'(e[12:11]);
         n_words = int'(e[10:8]); cur_seed = e[7:0];
         w0 = words_done; bm0 = bad_mosi; bh0 = bad_half; bs0 = bad_sel; rs0 = rx_seen; br0 = bad_rx;
         pulse_start();
         wait_idle();
         chk(words_done - w0 == n_words, "R5 words sent", words_done - w0, n_words);
         chk(bad_mosi == bm0, "R3 mosi words", bad_mosi - bm0, 0);
         chk(rx_seen - rs0 == n_words && bad_rx == br0, "R11 rx words", bad_rx - br0, 0);
         chk(bad_half == bh0, "R4 half period", bad_half - bh0, 0);
         chk(bad_sel == bs0, "R10 select line", bad_sel - bs0, 0);
         chk(last_tail == cur_h + 1, "R6 tail delay", last_tail, cur_h + 1);
         chk(sclk == e[16], "R2 idle sclk", sclk, e[16]);
      end

      // R8: illegal divide code is refused, old config kept (cpol 0)
      cfg_write(1, 0, 2'd3, 2'd0);
      chk(cfg_err == 1, "R8 bad div flag", cfg_err, 1);
      repeat (2) @(negedge clk);
      chk(sclk == 0, "R8 config kept", sclk, 0);
      n_words = 2;
      pulse_start();
      repeat (3) @(negedge clk);
      chk(busy == 0 && fifo_req == 0, "R8 start ignored", {busy, fifo_req}, 0);
      cfg_write(0, 0, 2'd0, 2'd3);
      chk(cfg_err == 1, "R8 bad slave flag", cfg_err, 1);
      cfg_write(0, 0, 2'd1, 2'd0);
      chk(cfg_err == 0, "R8 legal clears", cfg_err, 0);

      // R9: writes during a burst are ignored
      begin
         int w0, bs0, bm0;
         cur_cpha = 0; cur_h = 2; cur_sel = 0; n_words = 3; cur_seed = 8'h6E;
         w0 = words_done; bs0 = bad_sel; bm0 = bad_mosi;
         pulse_start();
         repeat (2) @(negedge clk);
         cfg_write(1, 1, 2'd2, 2'd0);
         chk(cfg_err == 0, "R9 no error while busy", cfg_err, 0);
         cfg_write(1, 1, 2'd0, 2'd2);
         wait_idle();
         chk(sclk == 0, "R9 cpol unchanged", sclk, 0);
         chk(words_done - w0 == 3 && bad_mosi == bm0 && bad_sel == bs0, "R9 burst intact",
             words_done - w0, 3);
      end

      // R7: silent FIFO
      begin
         int cnt = 0, f0;
         f0 = ss_falls;
         fifo_on = 0; n_words = 2;
         @(negedge clk); start = 1;
         @(negedge clk); start = 0;
         for (int k = 0; k < 500 && busy; k++) begin
            if (fifo_req) cnt++;
            @(negedge clk);
         end
         chk(cnt == WAITC, "R7 request length", cnt, WAITC);
         chk(fifo_err == 1, "R7 error flag", fifo_err, 1);
         chk(ss_falls == f0 && ss_n == '1, "R7 no select", ss_falls - f0, 0);
         fifo_on = 1;
      end

      // R12: empty FIFO on the first request; fifo_err clears on start (R7)
      begin
         int f0;
         f0 = ss_falls; n_words = 0;
         pulse_start();
         chk(fifo_err == 0, "R7 error cleared", fifo_err, 0);
         wait_idle();
         chk(ss_falls == f0, "R12 no select", ss_falls - f0, 0);
         chk(fifo_err == 0 && busy == 0, "R12 no error", {fifo_err, busy}, 0);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         $display("FAIL watchdog expired, actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
         $finish;
      end
   end
endmodule